// File: doc/BRIEF.md
# DDR2 Mode Register Controller

This block keeps the main mode register of a DDR2 memory controller and turns the stored word into the settings the rest of the controller uses: burst length, burst ordering, CAS latency, write recovery and power-down exit speed. Commands arrive on a valid/ready stream: an operation code, a two-bit bank-select field and a 15-bit address word. A LOAD MODE command aimed at bank-select 00 writes the register. After each accepted write the block applies the timing rules that follow a mode register write.

Timing rules: a guard interval holds back every command for a configurable number of cycles. A DLL-reset request is stored for a single cycle and then cleared by the block, and READ commands are held back until the DLL has had time to relock. A LOAD MODE sent while a bank is open or a burst is running is reported and dropped. A write with the test bit set changes only the test flag. A flag reports when a stored field holds a reserved code.

Back-pressure works as follows. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is computed combinationally from the block state and from the operation code being presented, so it may change within a cycle when the upstream changes `cmd_op`. The upstream must hold its command until it transfers. The block stores no commands; a command that transfers and is not LOAD MODE has no effect here.

Top module: `ddr2_modereg_ctl`

## Requirements
- R1: A transferred LOAD MODE with `cmd_bank` = 00, sent while `banks_idle`=1 and `burst_active`=0 and with address bit 7 = 0, stores the address word into `mode_word`, and the stored value is visible in the cycle after the transfer edge. A LOAD MODE with any other `cmd_bank` value leaves `mode_word` unchanged and does not start the guard.
- R2: `burst_len` is 4 when bits 2..0 are 010, 8 when they are 011, and 0 for any other code. `burst_interleave` equals bit 3 (1 = interleaved order).
- R3: `cas_latency` equals the value of bits 6..4 when that value is 3, 4, 5 or 6, and is 0 for any other code.
- R4: `write_recovery` is the value of bits 11..9 plus one when bits 11..9 hold 001 through 101 (2 to 6 clocks), and is 0 for any other code. `pd_slow_exit` equals bit 12 (1 = slow, low-power exit).
- R5: `reserved_code` is high exactly when the burst-length, CAS-latency or write-recovery field of the stored word holds a reserved code.
- R6: When a legal write sets bit 8, `mode_word[8]` reads 1 and `dll_reset_pulse` is high for the one cycle after the transfer edge. From the next cycle on, `mode_word[8]` reads 0.
- R7: `read_locked` is high for DLL_LOCK_CYCLES (default 200) cycles after the transfer edge of a legal write that sets bit 8. While it is high, `cmd_ready` is low when `cmd_op` is READ (code 3). Other operations are not held back by this lock.
- R8: A LOAD MODE to bank-select 00 that transfers while `banks_idle`=0 or `burst_active`=1 is dropped. `lm_error` is high for the single following cycle, `mode_word` stays the same, and no guard starts.
- R9: A legal write with address bit 7 = 1 sets `test_mode` (shown as `mode_word[7]`) and leaves all other bits unchanged. A later legal write with bit 7 = 0 clears `test_mode`.
- R10: After every legal write, `mrd_busy` is high for TMRD_CYCLES (default 2) cycles, and `cmd_ready` is low for every operation code during that time.
- R11: Operation codes are 0 NOP, 1 LOAD MODE, 2 ACTIVE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 REFRESH, 7 other. A command transfers only on an edge where `cmd_valid` and `cmd_ready` are both high. When neither the guard nor the READ lock applies, `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command may transfer this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_bank | input | 2 | Bank-select field |
| cmd_addr | input | 15 | Address word (mode bits) |
| banks_idle | input | 1 | All banks precharged |
| burst_active | input | 1 | A read or write burst is in progress |
| mode_word | output | 15 | Stored mode word; bit 7 shows test mode |
| burst_len | output | 4 | Decoded burst length (0 = reserved) |
| burst_interleave | output | 1 | 1 = interleaved burst order |
| cas_latency | output | 3 | Decoded CAS latency (0 = reserved) |
| write_recovery | output | 3 | Decoded write recovery in clocks (0 = reserved) |
| pd_slow_exit | output | 1 | 1 = slow power-down exit |
| test_mode | output | 1 | Test mode entered |
| dll_reset_pulse | output | 1 | DLL reset issued this cycle |
| mrd_busy | output | 1 | Mode-set guard interval running |
| read_locked | output | 1 | READ held back for DLL relock |
| lm_error | output | 1 | One-cycle flag for a dropped LOAD MODE |
| reserved_code | output | 1 | A stored field holds a reserved code |

## Verification
After a write that sets the DLL-reset bit, the guard interval and the READ lock begin on the same edge. For the first cycles a READ is held back by both, and after that by the lock alone. The bench presents a WRITE just after the guard ends and expects it to be ready while READ is still refused. It then presents a READ in the last locked cycle and in the first unlocked cycle, and expects `cmd_ready` to go from 0 to 1 exactly at the DLL_LOCK_CYCLES boundary. In the cycle right after the write, the self-clearing bit 8 and the start of the lock coincide, and the bench checks both in that cycle.

// File: rtl/ddr2_mr_pkg.sv
package ddr2_mr_pkg;

  localparam int MR_W = 15;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LOAD_MODE = 3'd1,
    OP_ACTIVE    = 3'd2,
    OP_READ      = 3'd3,
    OP_WRITE     = 3'd4,
    OP_PRECHARGE = 3'd5,
    OP_REFRESH   = 3'd6,
    OP_OTHER     = 3'd7
  } mr_cmd_e;

  // burst length field: 010 -> 4, 011 -> 8, else reserved (0)
  function automatic logic [3:0] bl_decode(input logic [2:0] code);
    case (code)
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // CAS latency field: codes 3..6 map to themselves
  function automatic logic [2:0] cl_decode(input logic [2:0] code);
    if (code >= 3'd3 && code <= 3'd6) return code;
    return 3'd0;
  endfunction

  // write recovery field: codes 1..5 map to 2..6 clocks
  function automatic logic [2:0] wr_decode(input logic [2:0] code);
    if (code >= 3'd1 && code <= 3'd5) return code + 3'd1;
    return 3'd0;
  endfunction

endpackage

// File: rtl/mr_timer.sv
module mr_timer #(
  parameter int COUNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  localparam int W = (COUNT < 1) ? 1 : $clog2(COUNT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= W'(COUNT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mr_store.sv
module mr_store
  import ddr2_mr_pkg::*;
#(
  parameter logic [MR_W-1:0] RESET_WORD = 15'h0232
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [MR_W-1:0] wr_word,
  output logic [MR_W-1:0] word_o,
  output logic            test_o,
  output logic            dll_pulse_o
);
  logic [MR_W-1:0] word_q;
  logic            dll_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= RESET_WORD;
      dll_q  <= 1'b0;
    end else begin
      dll_q <= wr_en && !wr_word[7] && wr_word[8];
      if (wr_en) begin
        if (wr_word[7]) word_q[7] <= 1'b1;
        else            word_q    <= wr_word;
      end else if (dll_q) begin
        word_q[8] <= 1'b0;
      end
    end
  end

  assign word_o      = word_q;
  assign test_o      = word_q[7];
  assign dll_pulse_o = dll_q;

  // R6
  dll_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_q && !wr_en) |=> !word_q[8]);

  // R9
  test_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_q[7]) |-> (word_q[14:8] == $past(word_q[14:8]) &&
                          word_q[6:0]  == $past(word_q[6:0])));

endmodule

// File: rtl/mr_decode.sv
module mr_decode
  import ddr2_mr_pkg::*;
(
  input  logic [2:0] bl_code,
  input  logic       bt_bit,
  input  logic [2:0] cl_code,
  input  logic [2:0] wr_code,
  input  logic       pd_bit,
  output logic [3:0] burst_len,
  output logic       interleave,
  output logic [2:0] cas_lat,
  output logic [2:0] wr_clk,
  output logic       pd_slow,
  output logic       reserved
);
  always_comb begin
    burst_len  = bl_decode(bl_code);
    cas_lat    = cl_decode(cl_code);
    wr_clk     = wr_decode(wr_code);
    interleave = bt_bit;
    pd_slow    = pd_bit;
    reserved   = (burst_len == 4'd0) || (cas_lat == 3'd0) || (wr_clk == 3'd0);
  end

endmodule

// File: rtl/ddr2_modereg_ctl.sv
module ddr2_modereg_ctl
  import ddr2_mr_pkg::*;
#(
  parameter int              TMRD_CYCLES     = 2,
  parameter int              DLL_LOCK_CYCLES = 200,
  parameter logic [MR_W-1:0] RESET_WORD      = 15'h0232
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [1:0]      cmd_bank,
  input  logic [MR_W-1:0] cmd_addr,
  input  logic            banks_idle,
  input  logic            burst_active,
  output logic [MR_W-1:0] mode_word,
  output logic [3:0]      burst_len,
  output logic            burst_interleave,
  output logic [2:0]      cas_latency,
  output logic [2:0]      write_recovery,
  output logic            pd_slow_exit,
  output logic            test_mode,
  output logic            dll_reset_pulse,
  output logic            mrd_busy,
  output logic            read_locked,
  output logic            lm_error,
  output logic            reserved_code
);
  logic is_read, lm_cmd, lm_legal, lm_bad, lock_load, err_q;

  assign is_read   = (cmd_op == OP_READ);
  assign cmd_ready = !mrd_busy && !(is_read && read_locked);

  assign lm_cmd    = cmd_valid && cmd_ready && (cmd_op == OP_LOAD_MODE) &&
                     (cmd_bank == 2'b00);
  assign lm_legal  = lm_cmd && banks_idle && !burst_active;
  assign lm_bad    = lm_cmd && !lm_legal;
  assign lock_load = lm_legal && !cmd_addr[7] && cmd_addr[8];

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= lm_bad;
  end
  assign lm_error = err_q;

  mr_store #(.RESET_WORD(RESET_WORD)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(lm_legal), .wr_word(cmd_addr),
    .word_o(mode_word), .test_o(test_mode), .dll_pulse_o(dll_reset_pulse)
  );

  mr_timer #(.COUNT(TMRD_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n), .load(lm_legal), .active(mrd_busy)
  );

  mr_timer #(.COUNT(DLL_LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(lock_load), .active(read_locked)
  );

  mr_decode u_dec (
    .bl_code(mode_word[2:0]), .bt_bit(mode_word[3]), .cl_code(mode_word[6:4]),
    .wr_code(mode_word[11:9]), .pd_bit(mode_word[12]),
    .burst_len(burst_len), .interleave(burst_interleave), .cas_lat(cas_latency),
    .wr_clk(write_recovery), .pd_slow(pd_slow_exit), .reserved(reserved_code)
  );

  // R7
  lock_with_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |-> read_locked);

  // R8
  err_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_error |-> ($stable(mode_word) && !mrd_busy));

  // R10
  guard_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_legal |=> (mrd_busy && !cmd_ready));

endmodule

// File: tb/test_ddr2_modereg_ctl.sv
`timescale 1ns/1ps
module test_ddr2_modereg_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_bank = 2'd0;
  logic [14:0] cmd_addr = 15'd0;
  logic        banks_idle = 1'b1;
  logic        burst_active = 1'b0;
  logic [14:0] mode_word;
  logic [3:0]  burst_len;
  logic        burst_interleave;
  logic [2:0]  cas_latency;
  logic [2:0]  write_recovery;
  logic        pd_slow_exit, test_mode, dll_reset_pulse, mrd_busy;
  logic        read_locked, lm_error, reserved_code;

  always #2 clk = ~clk;

  ddr2_modereg_ctl i_ddr2_modereg_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .banks_idle(banks_idle), .burst_active(burst_active),
    .mode_word(mode_word), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .cas_latency(cas_latency),
    .write_recovery(write_recovery), .pd_slow_exit(pd_slow_exit),
    .test_mode(test_mode), .dll_reset_pulse(dll_reset_pulse),
    .mrd_busy(mrd_busy), .read_locked(read_locked), .lm_error(lm_error),
    .reserved_code(reserved_code)
  );

  localparam int S_WORD = 0, S_BL = 1, S_IL = 2, S_CL = 3, S_WR = 4, S_PD = 5,
                 S_TEST = 6, S_BUSY = 7, S_LOCK = 8, S_RDY = 9, S_ERR = 10,
                 S_DLL = 11, S_RSV = 12;

  typedef struct { string req; int sel; int exp; } item_t;
  item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  function automatic int sample(int sel);
    case (sel)
      S_WORD: return int'(mode_word);
      S_BL:   return int'(burst_len);
      S_IL:   return int'(burst_interleave);
      S_CL:   return int'(cas_latency);
      S_WR:   return int'(write_recovery);
      S_PD:   return int'(pd_slow_exit);
      S_TEST: return int'(test_mode);
      S_BUSY: return int'(mrd_busy);
      S_LOCK: return int'(read_locked);
      S_RDY:  return int'(cmd_ready);
      S_ERR:  return int'(lm_error);
      S_DLL:  return int'(dll_reset_pulse);
      default: return int'(reserved_code);
    endcase
  endfunction

  task automatic expect_val(input string req, input int sel, input int val);
    item_t it;
    it.req = req; it.sel = sel; it.exp = val;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued expectations 1 ns after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      act = sample(it.sel);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  // transfers one command; returns on the falling edge after the transfer edge
  task automatic issue(input logic [2:0] op, input logic [1:0] bk, input logic [14:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bk; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1 R5 R10 R11)
    expect_val("R1", S_WORD, 'h0232);
    expect_val("R5", S_RSV, 0);
    expect_val("R10", S_BUSY, 0);
    expect_val("R11", S_RDY, 1);
    expect_val("R7", S_LOCK, 0);

    // full decode of a legal word
    issue(3'd1, 2'b00, 15'h1A5B);
    expect_val("R1", S_WORD, 'h1A5B);
    expect_val("R2", S_BL, 8);
    expect_val("R2", S_IL, 1);
    expect_val("R3", S_CL, 5);
    expect_val("R4", S_WR, 6);
    expect_val("R4", S_PD, 1);
    expect_val("R5", S_RSV, 0);
    expect_val("R10", S_BUSY, 1);
    cmd_valid = 1'b1; cmd_op = 3'd2;
    expect_val("R10", S_RDY, 0);
    @(negedge clk);
    expect_val("R10", S_BUSY, 1);
    expect_val("R10", S_RDY, 0);
    @(negedge clk);
    expect_val("R10", S_BUSY, 0);
    expect_val("R11", S_RDY, 1);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    settle();

    // all three fields reserved
    issue(3'd1, 2'b00, 15'h0070);
    expect_val("R2", S_BL, 0);
    expect_val("R2", S_IL, 0);
    expect_val("R3", S_CL, 0);
    expect_val("R4", S_WR, 0);
    expect_val("R4", S_PD, 0);
    expect_val("R5", S_RSV, 1);
    settle();

    // only write recovery reserved
    issue(3'd1, 2'b00, 15'h0C32);
    expect_val("R2", S_BL, 4);
    expect_val("R3", S_CL, 3);
    expect_val("R4", S_WR, 0);
    expect_val("R5", S_RSV, 1);
    settle();

    // other bank-select codes do not touch this register
    issue(3'd1, 2'b01, 15'h1A5B);
    expect_val("R1", S_WORD, 'h0C32);
    expect_val("R1", S_BUSY, 0);
    issue(3'd1, 2'b10, 15'h0232);
    expect_val("R1", S_WORD, 'h0C32);
    settle();

    // illegal LOAD MODE: bank open
    banks_idle = 1'b0;
    issue(3'd1, 2'b00, 15'h0232);
    expect_val("R8", S_ERR, 1);
    expect_val("R8", S_WORD, 'h0C32);
    expect_val("R8", S_BUSY, 0);
    @(negedge clk);
    expect_val("R8", S_ERR, 0);
    banks_idle = 1'b1;
    // illegal LOAD MODE: burst running
    burst_active = 1'b1;
    issue(3'd1, 2'b00, 15'h0232);
    expect_val("R8", S_ERR, 1);
    expect_val("R8", S_WORD, 'h0C32);
    burst_active = 1'b0;
    settle();

    // test mode: only the test flag changes
    issue(3'd1, 2'b00, 15'h1080);
    expect_val("R9", S_TEST, 1);
    expect_val("R9", S_WORD, 'h0CB2);
    expect_val("R9", S_PD, 0);
    settle();
    issue(3'd1, 2'b00, 15'h0232);
    expect_val("R9", S_TEST, 0);
    expect_val("R9", S_WORD, 'h0232);
    settle();

    // DLL reset: self-clearing bit and READ lock
    issue(3'd1, 2'b00, 15'h0332);
    expect_val("R6", S_WORD, 'h0332);
    expect_val("R6", S_DLL, 1);
    expect_val("R7", S_LOCK, 1);
    @(negedge clk);
    expect_val("R6", S_WORD, 'h0232);
    expect_val("R6", S_DLL, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    expect_val("R7", S_RDY, 1);
    @(negedge clk);
    cmd_op = 3'd3;
    expect_val("R7", S_RDY, 0);
    expect_val("R7", S_LOCK, 1);
    repeat (196) @(negedge clk);
    expect_val("R7", S_RDY, 0);
    expect_val("R7", S_LOCK, 1);
    @(negedge clk);
    expect_val("R7", S_RDY, 1);
    expect_val("R7", S_LOCK, 0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;

    repeat (3) @(negedge clk);
    finished = 1'b1;
    finish_run();
  end

endmodule